// File: doc/BRIEF.md
# Slot-Addressed Bus Node I/O Engine

This block is the digital core of a node on a two-wire, time-division multiplexed field bus. The bus master produces a repeating train of pulses: a long synchronization pulse, then up to 128 short pulses, each starting with a falling edge. Every pulse is one slot. The node counts falling edges from the last synchronization to find the current slot number. It then compares that number with the slot address programmed for each of its eight I/O pins. Each pin has its own address, its own valid flag and its own direction.

A pin configured as a transmitter whose address matches the current slot, and whose input pin is high, makes the node pull the line low as soon as the slot begins. The master detects this and stretches the low part of the pulse. A pin configured as a receiver measures the low width of its slot in sample ticks. A width at or above a threshold is a 1 and a shorter width is a 0. The received value reaches the output pin only once the opposite value has been seen in two consecutive frames.

The control is a three-state machine. `ST_HUNT` is entered at reset and leaves on the first synchronization strobe (transition *lock*) to `ST_GAP`. `ST_GAP` waits for a falling edge (transition *slot start*) to `ST_LOW`. `ST_LOW` returns to `ST_GAP` in three cases: when the line is sampled high (transition *decode*), when the low time reaches the slot length (transition *timeout*, no decision), or when a synchronization strobe arrives (transition *resync*). A synchronization strobe in `ST_GAP` stays in `ST_GAP` and clears the slot count.

Top module: `slot_node_engine`

## Requirements
- R1: After reset `out_state` is all zero and `pull_dn` is low. Falling edges before the first `sync_det` pulse are ignored: no pull-down occurs and no output changes.
- R2: A `sync_det` pulse clears the slot count. The first falling edge after it is slot 0, and each further falling edge is the next slot number.
- R3: A channel with valid=1 and dir=1 (transmit) whose 7-bit address equals the current slot, and whose `pin_in` bit is 1, drives `pull_dn` high from the clock edge that samples the slot's falling edge. The pull-down ends on the edge after the line is sampled high, or when the low time reaches SLOT_TICKS ticks.
- R4: There is no pull-down in a slot when a matching transmit pin is low, when its entry has valid=0, or when the matching entry has dir=0.
- R5: A receive slot decodes as 1 when the number of low ticks, counting the tick that saw the falling edge, is at least LOW_THRESH (default 12). Otherwise it decodes as 0: a width of 12 gives 1 and a width of 11 gives 0.
- R6: The output of a valid receive channel (valid=1, dir=0) changes only after the opposite value has been decoded in its slot in two consecutive frames. A single differing frame followed by an agreeing one leaves the output unchanged.
- R7: Several channels programmed to the same slot are all serviced in that slot.
- R8: A receive channel with valid=0 never changes its output.
- R9: Slot 127 is addressable. Falling edges after the 128th edge of a frame match no address, so no pull-down occurs even for a transmit pin at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Line sample enable |
| line_lvl | input | 1 | Filtered bus line level |
| sync_det | input | 1 | Synchronization-detected strobe |
| cfg_addr | input | NCH*AW | Slot address per channel, channel i at bits [i*AW +: AW] |
| cfg_valid | input | NCH | Channel address valid |
| cfg_dir | input | NCH | 1 = transmit (input pin), 0 = receive (output pin) |
| pin_in | input | NCH | Input pin states |
| pull_dn | output | 1 | Open-collector pull-down enable |
| out_state | output | NCH | Received output pin states |

## Verification
The bound checker watches the following on every cycle:
- the pull-down is dropped after the line is seen high;
- the pull-down and outputs stay quiet while hunting for synchronization;
- the slot count is cleared by synchronization and only steps by one, and it never passes 128;
- outputs change only in the cycle after a decode.

Only the bench scenarios can show the rest: that the right slot number is matched, that the 11/12-tick threshold falls where it should, that the two-frame confirmation is correct for each channel, and that shared and invalid entries behave as required. For these the bench acts as the bus master and stretches the pulses in response to the observed pull-down.

// File: rtl/node_pkg.sv
package node_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_GAP  = 2'd1,
        ST_LOW  = 2'd2
    } node_state_e;
endpackage

// File: rtl/slot_tracker.sv
module slot_tracker #(
    parameter int NUM_SLOTS = 128,
    parameter int CW        = $clog2(NUM_SLOTS) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line_lvl,
    input  logic          sync_det,
    input  logic          armed,
    output logic          fall,
    output logic [CW-1:0] slot_cnt,
    output logic          in_range
);
    logic prev_lvl;

    assign fall     = tick && prev_lvl && !line_lvl;
    assign in_range = (slot_cnt < CW'(NUM_SLOTS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_lvl <= 1'b1;
            slot_cnt <= '0;
        end else begin
            if (tick)
                prev_lvl <= line_lvl;
            if (sync_det)
                slot_cnt <= '0;
            else if (fall && armed && in_range)
                slot_cnt <= slot_cnt + CW'(1);
        end
    end
endmodule

// File: rtl/slot_match.sv
module slot_match #(
    parameter int NCH = 8,
    parameter int AW  = 7
) (
    input  logic [NCH*AW-1:0] cfg_addr,
    input  logic [NCH-1:0]    cfg_valid,
    input  logic [NCH-1:0]    cfg_dir,
    input  logic [NCH-1:0]    pin_in,
    input  logic [AW-1:0]     slot_idx,
    input  logic              in_range,
    output logic              tx_req,
    output logic [NCH-1:0]    rx_hit
);
    logic [NCH-1:0] tx_hit;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit       = in_range && cfg_valid[i] && (cfg_addr[i*AW +: AW] == slot_idx);
        assign tx_hit[i] = hit && cfg_dir[i] && pin_in[i];
        assign rx_hit[i] = hit && !cfg_dir[i];
    end

    assign tx_req = |tx_hit;
endmodule

// File: rtl/out_filter.sv
module out_filter #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] upd,
    input  logic           bit_val,
    output logic [NCH-1:0] out_state
);
    for (genvar i = 0; i < NCH; i++) begin : g_flt
        logic pend;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_state[i] <= 1'b0;
                pend         <= 1'b0;
            end else if (upd[i]) begin
                if (bit_val == out_state[i]) begin
                    pend <= 1'b0;
                end else if (pend) begin
                    out_state[i] <= bit_val;
                    pend         <= 1'b0;
                end else begin
                    pend <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/slot_node_engine.sv
module slot_node_engine
    import node_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int NUM_SLOTS  = 128,
    parameter int SLOT_TICKS = 32,
    parameter int LOW_THRESH = 12,
    parameter int AW         = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_lvl,
    input  logic              sync_det,
    input  logic [NCH*AW-1:0] cfg_addr,
    input  logic [NCH-1:0]    cfg_valid,
    input  logic [NCH-1:0]    cfg_dir,
    input  logic [NCH-1:0]    pin_in,
    output logic              pull_dn,
    output logic [NCH-1:0]    out_state
);
    localparam int CNT_W = AW + 1;
    localparam int LW    = $clog2(SLOT_TICKS + 1);

    node_state_e    state_q, state_d;
    logic [LW-1:0]  low_cnt;
    logic           tx_q;
    logic [NCH-1:0] rx_q;

    logic             fall, in_range, tx_req, dec, timeout;
    logic [CNT_W-1:0] slot_cnt;
    logic [NCH-1:0]   rx_hit;

    slot_tracker #(.NUM_SLOTS(NUM_SLOTS), .CW(CNT_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_lvl(line_lvl),
        .sync_det(sync_det), .armed(state_q == ST_GAP),
        .fall(fall), .slot_cnt(slot_cnt), .in_range(in_range)
    );

    slot_match #(.NCH(NCH), .AW(AW)) u_match (
        .cfg_addr(cfg_addr), .cfg_valid(cfg_valid), .cfg_dir(cfg_dir),
        .pin_in(pin_in), .slot_idx(slot_cnt[AW-1:0]), .in_range(in_range),
        .tx_req(tx_req), .rx_hit(rx_hit)
    );

    assign dec     = (state_q == ST_LOW) && tick && line_lvl && !sync_det;
    assign timeout = (state_q == ST_LOW) && tick && !line_lvl &&
                     (low_cnt == LW'(SLOT_TICKS - 1));

    out_filter #(.NCH(NCH)) u_flt (
        .clk(clk), .rst_n(rst_n),
        .upd(dec ? rx_q : '0),
        .bit_val(low_cnt >= LW'(LOW_THRESH)),
        .out_state(out_state)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (sync_det) state_d = ST_GAP;
            ST_GAP:  if (!sync_det && fall) state_d = ST_LOW;
            ST_LOW:  if (sync_det || dec || timeout) state_d = ST_GAP;
            default: state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // slot data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            tx_q    <= 1'b0;
            rx_q    <= '0;
        end else if (state_q == ST_GAP && state_d == ST_LOW) begin
            low_cnt <= LW'(1);
            tx_q    <= tx_req;
            rx_q    <= rx_hit;
        end else if (state_q == ST_LOW && tick && !line_lvl) begin
            low_cnt <= low_cnt + LW'(1);
        end
    end

    // outputs
    always_comb begin
        pull_dn = (state_q == ST_LOW) && tx_q;
    end
endmodule

// File: rtl/slot_node_engine_check.sv
module slot_node_engine_check
    import node_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int CW        = 8,
    parameter int NUM_SLOTS = 128
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick,
    input logic           line_lvl,
    input logic           sync_det,
    input logic           pull_dn,
    input logic [NCH-1:0] out_state,
    input node_state_e    state_q,
    input logic [CW-1:0]  slot_cnt,
    input logic           dec
);
    assert_release_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && line_lvl && pull_dn) |=> !pull_dn);

    assert_quiet_in_hunt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT) |-> (!pull_dn && out_state == '0));

    assert_sync_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_det |=> (slot_cnt == '0));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_det |=> (CW'(slot_cnt - $past(slot_cnt)) <= CW'(1)));

    assert_count_capped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_cnt <= CW'(NUM_SLOTS));

    assert_out_on_decode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_state != $past(out_state)) |-> $past(dec));
endmodule

bind slot_node_engine slot_node_engine_check #(
    .NCH(NCH), .CW(CNT_W), .NUM_SLOTS(NUM_SLOTS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_lvl(line_lvl),
    .sync_det(sync_det), .pull_dn(pull_dn), .out_state(out_state),
    .state_q(state_q), .slot_cnt(slot_cnt), .dec(dec)
);

// File: tb/slot_node_engine_test.sv
module slot_node_engine_test;
    localparam int NCH = 8;
    localparam int AW  = 7;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, line_lvl = 1'b1, sync_det = 1'b0;
    logic [NCH*AW-1:0] cfg_addr;
    logic [NCH-1:0]    cfg_valid, cfg_dir, pin_in;
    logic              pull_dn;
    logic [NCH-1:0]    out_state;

    int  checks = 0, errors = 0;
    logic [AW-1:0] addr_tb [NCH];
    bit  exp_out [NCH];
    bit  exp_pend [NCH];

    always #4 clk = ~clk;

    always_comb
        for (int i = 0; i < NCH; i++) cfg_addr[i*AW +: AW] = addr_tb[i];

    slot_node_engine uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_lvl(line_lvl),
        .sync_det(sync_det), .cfg_addr(cfg_addr), .cfg_valid(cfg_valid),
        .cfg_dir(cfg_dir), .pin_in(pin_in), .pull_dn(pull_dn), .out_state(out_state)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    function automatic bit exp_pull(int s);
        bit r = 0;
        if (s < 128)
            for (int i = 0; i < NCH; i++)
                if (cfg_valid[i] && cfg_dir[i] && pin_in[i] && addr_tb[i] == s) r = 1;
        return r;
    endfunction

    task automatic do_sync();
        line_lvl = 1'b1;
        sync_det = 1'b1;
        cyc();
        sync_det = 1'b0;
        cyc();
        cyc();
    endtask

    // one slot as bus master: stretch low when node pulls or host bit is 1
    task automatic do_slot(int s, bit host_bit, int w1, int w0, bit hunting);
        bit pulled;
        int lw;
        line_lvl = 1'b0;
        cyc();
        pulled = pull_dn;
        if (hunting)
            chk(pulled == 1'b0, "R1 no pull before sync", pulled, 0);
        else if (s >= 128)
            chk(pulled == 1'b0, "R9 slot beyond 127", pulled, 0);
        else
            chk(pulled == exp_pull(s), "R3/R4 pull in slot", pulled, exp_pull(s));
        lw = (host_bit || pulled) ? w1 : w0;
        repeat (lw - 1) cyc();
        line_lvl = 1'b1;
        cyc();
        chk(pull_dn == 1'b0, "R3 release on high", pull_dn, 0);
        repeat (5) cyc();
    endtask

    task automatic frame(int n, logic [127:0] host, int extra, int w1, int w0);
        do_sync();
        for (int s = 0; s < n; s++) do_slot(s, host[s], w1, w0, 1'b0);
        for (int e = 0; e < extra; e++) do_slot(128 + e, 1'b1, w1, w0, 1'b0);
        // model update: two-frame confirmation
        for (int i = 0; i < NCH; i++) begin
            if (cfg_valid[i] && !cfg_dir[i] && addr_tb[i] < n) begin
                bit b = host[addr_tb[i]] | exp_pull(addr_tb[i]);
                if (b == exp_out[i]) exp_pend[i] = 0;
                else if (exp_pend[i]) begin exp_out[i] = b; exp_pend[i] = 0; end
                else exp_pend[i] = 1;
            end
        end
        for (int i = 0; i < NCH; i++) begin
            string req = (i == 5) ? "R8 invalid rx" : (i == 2 || i == 3) ? "R7 shared slot" : "R6 output";
            chk(out_state[i] == exp_out[i], req, out_state[i], exp_out[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] host;
        void'($urandom(32'd2024));
        addr_tb[0] = 7'd3;   addr_tb[1] = 7'd3;  addr_tb[2] = 7'd5;  addr_tb[3] = 7'd5;
        addr_tb[4] = 7'd7;   addr_tb[5] = 7'd9;  addr_tb[6] = 7'd127; addr_tb[7] = 7'd0;
        cfg_dir   = 8'b1001_0001;
        cfg_valid = 8'b1100_1111;
        pin_in    = 8'b1001_0001;
        for (int i = 0; i < NCH; i++) begin exp_out[i] = 0; exp_pend[i] = 0; end
        repeat (3) cyc();
        chk(pull_dn == 1'b0, "R1 reset pull", pull_dn, 0);
        chk(out_state == '0, "R1 reset outputs", out_state, 0);
        rst_n = 1'b1;
        cyc();
        // edges before first sync are ignored
        for (int k = 0; k < 3; k++) do_slot(0, 1'b1, 16, 8, 1'b1);
        chk(out_state == '0, "R1 outputs after hunting", out_state, 0);

        // R5 threshold: width 12 decodes as 1, width 11 as 0 (ch1, slot 3, pin ch0 low)
        pin_in = 8'b0000_0000;
        host = '0; host[3] = 1'b1; host[5] = 1'b1;
        frame(12, host, 0, 12, 11);
        chk(out_state[1] == 1'b0, "R5/R6 first frame pending", out_state[1], 0);
        frame(12, host, 0, 12, 11);
        chk(out_state[1] == 1'b1, "R5 width 12 is one", out_state[1], 1);
        host = '0;
        frame(12, host, 0, 12, 11);
        frame(12, host, 0, 12, 11);
        chk(out_state[1] == 1'b0, "R5 width 11 is zero", out_state[1], 0);

        // random frames
        for (int f = 0; f < 30; f++) begin
            host   = {$urandom, $urandom, $urandom, $urandom};
            pin_in = NCH'($urandom);
            frame(12, host, 0, 16, 8);
        end

        // R9: full frames, slot 127 reachable, extra edges match nothing
        pin_in = 8'b1000_0000;
        host = '0; host[127] = 1'b1;
        frame(128, host, 2, 16, 8);
        frame(128, host, 2, 16, 8);
        chk(out_state[6] == 1'b1, "R9 slot 127 received", out_state[6], 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule